// File: doc/BRIEF.md
# Link-Event LED Controller

This block drives three status LEDs for a multi-speed Ethernet port. Each LED has two event masks. A steady mask picks the link conditions that keep the LED lit: link up at a given speed, link down, or forced on. A blink mask picks the traffic strobes that make the LED flash: transmit or receive activity at a given speed, or forced blink. Whenever a selected blink event is active, blinking overrides the steady result. The LED then follows a shared waveform. Its period and its lit portion are both programmable, counted in prescaled ticks of the system clock.

Software programs the block through a word-wide register file. It holds a global control word, the lit-time word, the blink-period word, and two control words per LED. The lane outputs are registered, so each LED pin changes one clock after its cause. A single-cycle activity strobe is stretched so that it always yields at least one full blink period. A per-LED polarity bit selects whether the pin is active-high or active-low. A disabled LED, or a disabled global mode, drives the inactive level.

Top module: `led_event_ctrl`

## Requirements
- R1: The register map is as follows. 0x21 is global control: bit 15 user control, bit 3 tick enable, bits [1:0] mode. 0x22 is the lit time and 0x23 the blink period, each 16 bits. 0x24+2*i is the steady word of LED i: bit 15 enable, bit 14 active-high, bits [8:0] steady mask. 0x25+2*i is the blink word of LED i, with bits [11:0] the blink mask. Unused bits and unmapped addresses read as zero.
- R2: link_speed is encoded 0=100M, 1=1000M, 2=2500M, 3=none. The steady mask bits are: bit 0 up at 1000M, bit 1 up at 100M, bit 3 link down, bit 6 force on, bit 8 up at 2500M. The LED is steadily lit when any selected condition holds, and the pin changes one clock after its input.
- R3: The blink mask bits are: bit 0 1000M TX, bit 1 1000M RX, bit 2 100M TX, bit 3 100M RX, bit 10 2500M TX, bit 11 2500M RX. Bit 9 forces blinking. A strobe whose bit is clear has no effect.
- R4: While a blink event is active, the LED follows the blink waveform even when the steady mask would hold it lit.
- R5: One tick occurs every TICK_DIV clocks. The blink waveform is lit for ticks 0 to lit_time-1 of each period and repeats every blink_period ticks.
- R6: A single-cycle selected strobe keeps blinking active for at least one full period. Blinking then stops after at most two period boundaries with no new strobe.
- R7: With bit 14 set, a lit LED drives 1. With bit 14 clear, a lit LED drives 0.
- R8: With bit 15 of the steady word clear, the LED drives its inactive level. Its masks and polarity are retained and read back unchanged.
- R9: With global mode 0, or with global bit 15 clear, every LED drives its inactive level.
- R10: With global bit 3 clear the tick stops, and the blink waveform freezes.
- R11: After reset all registers read zero and every LED pin is 1, the inactive level for active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| link_up | input | 1 | Link is up |
| link_speed | input | 2 | Current speed code |
| tx_act | input | 3 | TX activity strobes, index 0=1000M, 1=100M, 2=2500M |
| rx_act | input | 3 | RX activity strobes, same indexing |
| led_o | output | 3 | LED pins with polarity applied |

## Verification
The hardest case to reach from the ports is the activity stretch. A one-cycle strobe has to produce a whole visible period no matter where in the waveform it lands, and then has to die away. The stimulus issues isolated single-cycle strobes and counts lit cycles across windows that span several periods after each strobe. It then counts again in a later window, which must be dark. The duty checks use windows that are exact multiples of the period, so the lit count is fixed whatever the phase.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] ADDR_GLOB   = 8'h21;
  localparam logic [REG_AW-1:0] ADDR_LIT    = 8'h22;
  localparam logic [REG_AW-1:0] ADDR_PERIOD = 8'h23;
  localparam logic [REG_AW-1:0] ADDR_LANE0  = 8'h24;

  localparam int STEADY_W = 9;
  localparam int BLINK_W  = 12;
  localparam int BIT_FORCE_BLINK = 9;

  typedef struct packed {
    logic                en;
    logic                act_high;
    logic [STEADY_W-1:0] steady_mask;
    logic [BLINK_W-1:0]  blink_mask;
  } lane_cfg_t;
endpackage

// File: rtl/lec_regs.sv
module lec_regs
  import lec_pkg::*;
#(
  parameter int NUM_LED = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [REG_AW-1:0]             addr,
  input  logic [REG_DW-1:0]             wdata,
  output logic [REG_DW-1:0]             rdata,
  output lane_cfg_t [NUM_LED-1:0]       cfg,
  output logic                          glob_act,
  output logic                          tick_en,
  output logic [REG_DW-1:0]             lit_time,
  output logic [REG_DW-1:0]             period
);
  logic              user_q, user_d;
  logic              clken_q, clken_d;
  logic [1:0]        mode_q, mode_d;
  logic [REG_DW-1:0] lit_q, lit_d, per_q, per_d;
  lane_cfg_t [NUM_LED-1:0] cfg_q, cfg_d;

  always_comb begin
    user_d  = user_q;
    clken_d = clken_q;
    mode_d  = mode_q;
    lit_d   = lit_q;
    per_d   = per_q;
    cfg_d   = cfg_q;
    if (wr) begin
      if (addr == ADDR_GLOB) begin
        user_d  = wdata[15];
        clken_d = wdata[3];
        mode_d  = wdata[1:0];
      end
      if (addr == ADDR_LIT)    lit_d = wdata;
      if (addr == ADDR_PERIOD) per_d = wdata;
      for (int i = 0; i < NUM_LED; i++) begin
        if (addr == ADDR_LANE0 + REG_AW'(2*i)) begin
          cfg_d[i].en          = wdata[15];
          cfg_d[i].act_high    = wdata[14];
          cfg_d[i].steady_mask = wdata[STEADY_W-1:0];
        end
        if (addr == ADDR_LANE0 + REG_AW'(2*i+1)) begin
          cfg_d[i].blink_mask = wdata[BLINK_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q  <= 1'b0;
      clken_q <= 1'b0;
      mode_q  <= 2'd0;
      lit_q   <= '0;
      per_q   <= '0;
      cfg_q   <= '0;
    end else begin
      user_q  <= user_d;
      clken_q <= clken_d;
      mode_q  <= mode_d;
      lit_q   <= lit_d;
      per_q   <= per_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_GLOB) begin
      rdata[15]  = user_q;
      rdata[3]   = clken_q;
      rdata[1:0] = mode_q;
    end
    if (addr == ADDR_LIT)    rdata = lit_q;
    if (addr == ADDR_PERIOD) rdata = per_q;
    for (int i = 0; i < NUM_LED; i++) begin
      if (addr == ADDR_LANE0 + REG_AW'(2*i)) begin
        rdata[15]           = cfg_q[i].en;
        rdata[14]           = cfg_q[i].act_high;
        rdata[STEADY_W-1:0] = cfg_q[i].steady_mask;
      end
      if (addr == ADDR_LANE0 + REG_AW'(2*i+1)) begin
        rdata[BLINK_W-1:0] = cfg_q[i].blink_mask;
      end
    end
  end

  assign cfg      = cfg_q;
  assign glob_act = user_q && (mode_q != 2'd0);
  assign tick_en  = clken_q;
  assign lit_time = lit_q;
  assign period   = per_q;
endmodule

// File: rtl/lec_tick.sv
module lec_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/lec_phase.sv
module lec_phase #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] period,
  input  logic [DW-1:0] lit_time,
  output logic [DW-1:0] cnt,
  output logic          at_end,
  output logic          wrap,
  output logic          phase_on
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign at_end = (period == '0) || (cnt_q >= period - 1'b1);
  assign wrap   = tick && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign phase_on = (cnt_q < lit_time);
endmodule

// File: rtl/lec_lane.sv
module lec_lane
  import lec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lane_cfg_t cfg,
  input  logic      glob_act,
  input  logic      link_up,
  input  logic [1:0] link_speed,
  input  logic [2:0] tx_act,
  input  logic [2:0] rx_act,
  input  logic      wrap,
  input  logic      phase_on,
  output logic      led
);
  logic [STEADY_W-1:0] cond;
  logic [BLINK_W-1:0]  act;
  logic hit, steady, blinking, lit;
  logic pend_q, pend_d, armed_q, armed_d, led_q, led_d;

  always_comb begin
    cond    = '0;
    cond[0] = link_up && (link_speed == 2'd1);
    cond[1] = link_up && (link_speed == 2'd0);
    cond[3] = !link_up;
    cond[6] = 1'b1;
    cond[8] = link_up && (link_speed == 2'd2);
    act     = '0;
    act[0]  = tx_act[0];
    act[1]  = rx_act[0];
    act[2]  = tx_act[1];
    act[3]  = rx_act[1];
    act[10] = tx_act[2];
    act[11] = rx_act[2];
  end

  assign steady = |(cond & cfg.steady_mask);
  assign hit    = |(act & cfg.blink_mask);

  // Stretch: survive the first period boundary after a strobe, clear on the second.
  always_comb begin
    pend_d  = pend_q;
    armed_d = armed_q;
    if (hit) begin
      pend_d  = 1'b1;
      armed_d = 1'b0;
    end else if (wrap && pend_q) begin
      if (armed_q) begin
        pend_d  = 1'b0;
        armed_d = 1'b0;
      end else begin
        armed_d = 1'b1;
      end
    end
  end

  assign blinking = pend_q || cfg.blink_mask[BIT_FORCE_BLINK];
  assign lit      = glob_act && cfg.en && (blinking ? phase_on : steady);
  assign led_d    = cfg.act_high ? lit : !lit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      led_q   <= 1'b1;
    end else begin
      pend_q  <= pend_d;
      armed_q <= armed_d;
      led_q   <= led_d;
    end
  end

  assign led = led_q;
endmodule

// File: rtl/led_event_ctrl.sv
module led_event_ctrl
  import lec_pkg::*;
#(
  parameter int NUM_LED  = 3,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              link_up,
  input  logic [1:0]        link_speed,
  input  logic [2:0]        tx_act,
  input  logic [2:0]        rx_act,
  output logic [2:0]        led_o
);
  logic rst_m, rst_sn;
  lane_cfg_t [NUM_LED-1:0] cfg;
  logic glob_act, tick_en, tick, at_end, wrap, phase_on;
  logic [REG_DW-1:0] lit_time, period, tmr_cnt;
  logic [NUM_LED-1:0] lane_led;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_sn <= rst_m;
    end
  end

  lec_regs #(.NUM_LED(NUM_LED)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .glob_act(glob_act),
    .tick_en(tick_en), .lit_time(lit_time), .period(period)
  );

  lec_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_sn), .en(tick_en), .tick(tick)
  );

  lec_phase #(.DW(REG_DW)) u_phase (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .period(period),
    .lit_time(lit_time), .cnt(tmr_cnt), .at_end(at_end), .wrap(wrap),
    .phase_on(phase_on)
  );

  for (genvar i = 0; i < NUM_LED; i++) begin : g_lane
    lec_lane u_lane (
      .clk(clk), .rst_n(rst_sn), .cfg(cfg[i]), .glob_act(glob_act),
      .link_up(link_up), .link_speed(link_speed), .tx_act(tx_act),
      .rx_act(rx_act), .wrap(wrap), .phase_on(phase_on), .led(lane_led[i])
    );
  end

  assign led_o = lane_led[2:0];
endmodule

// File: rtl/lec_checker.sv
module lec_checker
  import lec_pkg::*;
#(
  parameter int NUM_LED = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    glob_act,
  input logic                    tick_en,
  input logic                    tick,
  input logic                    at_end,
  input logic [REG_DW-1:0]       tmr_cnt,
  input lane_cfg_t [NUM_LED-1:0] cfg,
  input logic [NUM_LED-1:0]      led,
  input logic [REG_AW-1:0]       reg_addr,
  input logic [REG_DW-1:0]       reg_rdata
);
  // R9: global disable forces inactive level on every lane
  for (genvar i = 0; i < NUM_LED; i++) begin : g_chk
    a_r9_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_act |=> (led[i] == !$past(cfg[i].act_high)));
    // R8: a disabled lane drives its inactive level
    a_r8_lane_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[i].en |=> (led[i] == !$past(cfg[i].act_high)));
  end

  // R10: tick disabled freezes the waveform counter
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tmr_cnt));

  // R5: period boundary restarts the waveform
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_end) |=> (tmr_cnt == '0));

  // R1: reserved bits of lane words read zero
  a_r1_steady_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_LANE0) |-> (reg_rdata[13:9] == 5'd0));
  a_r1_blink_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_LANE0 + 8'd1) |-> (reg_rdata[15:12] == 4'd0));
endmodule

bind led_event_ctrl lec_checker #(.NUM_LED(NUM_LED)) u_chk (
  .clk(clk), .rst_n(rst_sn), .glob_act(glob_act), .tick_en(tick_en),
  .tick(tick), .at_end(at_end), .tmr_cnt(tmr_cnt), .cfg(cfg),
  .led(lane_led), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/sim_led_event_ctrl.sv
`timescale 1ns/1ps
module sim_led_event_ctrl;
  logic clk, rst_n, reg_wr, link_up;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [1:0] link_speed;
  logic [2:0] tx_act, rx_act, led_o;
  int checks, fails, cnt;
  bit done;

  led_event_ctrl #(.NUM_LED(3), .TICK_DIV(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .link_speed(link_speed), .tx_act(tx_act), .rx_act(rx_act), .led_o(led_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {link_up, speed[1:0], steady_mask[8:0], expected LED0}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 2'd1, 9'h001, 1'b1},
    {1'b1, 2'd0, 9'h001, 1'b0},
    {1'b1, 2'd0, 9'h002, 1'b1},
    {1'b0, 2'd1, 9'h008, 1'b1},
    {1'b1, 2'd1, 9'h008, 1'b0},
    {1'b1, 2'd2, 9'h100, 1'b1},
    {1'b1, 2'd3, 9'h103, 1'b0},
    {1'b0, 2'd0, 9'h040, 1'b1}
  };

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic count_lit(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (led_o[0]) c++;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_tx0();
    @(negedge clk); tx_act[0] = 1'b1;
    @(negedge clk); tx_act[0] = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    link_up = 1'b0; link_speed = 2'd0; tx_act = '0; rx_act = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk(led_o, 3'b111, "R11 leds after reset");
    rreg(8'h24, rd); chk(rd, 16'h0000, "R11 lane0 word after reset");
    rreg(8'h21, rd); chk(rd, 16'h0000, "R11 global after reset");

    // R1 readback and reserved bits
    wreg(8'h24, 16'hFFFF); rreg(8'h24, rd); chk(rd, 16'hC1FF, "R1 steady word mask");
    wreg(8'h25, 16'hFFFF); rreg(8'h25, rd); chk(rd, 16'h0FFF, "R1 blink word mask");
    wreg(8'h21, 16'hFFFF); rreg(8'h21, rd); chk(rd, 16'h800B, "R1 global mask");
    wreg(8'h22, 16'hA5C3); rreg(8'h22, rd); chk(rd, 16'hA5C3, "R1 lit time");
    rreg(8'h40, rd); chk(rd, 16'h0000, "R1 unmapped address");
    wreg(8'h29, 16'h0ABC); rreg(8'h29, rd); chk(rd, 16'h0ABC, "R1 lane2 blink word");
    wreg(8'h29, 16'h0000);

    // R2 steady decode via vector table
    wreg(8'h21, 16'h8009);
    wreg(8'h25, 16'h0000);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      link_up = VEC[v][12]; link_speed = VEC[v][11:10];
      wreg(8'h24, {2'b11, 5'd0, VEC[v][9:1]});
      settle();
      chk(led_o[0], VEC[v][0], $sformatf("R2 steady vector %0d", v));
    end

    // R7 polarity, R9 global off
    link_up = 1'b0;
    wreg(8'h24, 16'hC040);
    wreg(8'h26, 16'h8040);
    wreg(8'h28, 16'h0000);
    settle(); chk(led_o, 3'b101, "R7 polarity lit levels");
    wreg(8'h21, 16'h0009); settle(); chk(led_o, 3'b110, "R9 user control clear");
    wreg(8'h21, 16'h8008); settle(); chk(led_o, 3'b110, "R9 mode zero");
    wreg(8'h21, 16'h8009);

    // R8 disable keeps masks
    wreg(8'h24, 16'h4040); settle(); chk(led_o[0], 0, "R8 disabled inactive");
    rreg(8'h24, rd); chk(rd, 16'h4040, "R8 masks retained");
    wreg(8'h24, 16'hC040); settle(); chk(led_o[0], 1, "R8 re-enable lights");

    // R5 duty: period 8 ticks * 4 clocks = 32 clocks
    wreg(8'h23, 16'd8); wreg(8'h22, 16'd4);
    wreg(8'h24, 16'hC000); wreg(8'h25, 16'h0200);
    settle(); count_lit(128, cnt); chk(cnt, 64, "R5 duty half");
    wreg(8'h22, 16'd2); settle(); count_lit(128, cnt); chk(cnt, 32, "R5 duty quarter");

    // R4 blink over steady
    wreg(8'h24, 16'hC040); settle(); count_lit(128, cnt); chk(cnt, 32, "R4 blink priority");
    wreg(8'h25, 16'h0000); settle(); count_lit(128, cnt); chk(cnt, 128, "R4 steady after blink off");

    // R6 stretch and R3 mask selection
    wreg(8'h22, 16'd4); wreg(8'h24, 16'hC000); wreg(8'h25, 16'h0001);
    settle(); count_lit(64, cnt); chk(cnt, 0, "R6 idle dark");
    pulse_tx0(); count_lit(96, cnt); chk(cnt >= 16, 1, "R6 strobe gives full period");
    repeat (96) @(negedge clk);
    count_lit(64, cnt); chk(cnt, 0, "R6 blink stops after stretch");
    @(negedge clk); rx_act[2] = 1'b1; @(negedge clk); rx_act[2] = 1'b0;
    count_lit(96, cnt); chk(cnt, 0, "R3 unselected strobe ignored");
    wreg(8'h25, 16'h0800);
    @(negedge clk); rx_act[2] = 1'b1; @(negedge clk); rx_act[2] = 1'b0;
    count_lit(96, cnt); chk(cnt >= 16, 1, "R3 2500M RX strobe selected");
    repeat (96) @(negedge clk);

    // R10 tick gate freezes waveform
    wreg(8'h25, 16'h0200); wreg(8'h21, 16'h8001);
    settle(); count_lit(128, cnt);
    chk((cnt == 0) || (cnt == 128), 1, "R10 frozen waveform");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule